// File: doc/BRIEF.md
# Legacy I/O Port Address Router

The router takes one 16-bit I/O port access per cycle and turns it into a 64-bit physical request address with two attribute flags: `uncached` for ordinary port traffic and `int_reg` for accesses that target the router's own configuration-address register. It implements the indirect two-port scheme for reaching PCI configuration space. Software first writes a 32-bit selector to the address port 0xCF8. Later accesses to the four data ports 0xCFC to 0xCFF are sent into a PCI configuration window when the selector's top bit is set, and into the plain I/O window when it is clear.

The address decode is combinational. The only state is the selector register, which loads on the clock edge that ends a 4-byte write to 0xCF8. A 4-byte read of 0xCF8 returns the register's value on `rdata`. Any other port number, and any access to 0xCF8 that is not 4 bytes wide, is sent to the I/O window unchanged and flagged uncached. The port input is exactly 16 bits wide, so a port number outside the 16-bit space cannot be presented.

Top module: `ioport_router`

## Requirements
- R1: After reset the selector register is zero, so a 4-byte read of port 0xCF8 returns `rdata` = 0.
- R2: A valid access to port 0xCF8 with `acc_size` = 4 sets `int_reg`=1, `uncached`=0 and `phys_addr`=0. If `acc_write`=1, the register takes `acc_wdata` at that clock edge. If `acc_write`=0, `rdata` shows the register value in the same cycle.
- R3: A valid access to port 0xCF8 with `acc_size` other than 4 is an ordinary port access: `phys_addr` = IO_BASE | port, `uncached`=1 and `int_reg`=0. Such an access leaves the register unchanged even when it is a write.
- R4: Every valid access to a data port (port & 0xFFFC == 0xCFC) gives `uncached`=1 and `int_reg`=0. Every valid access has exactly one of `uncached` and `int_reg` set.
- R5: For a data-port access while register bit 31 is 1, `phys_addr` = PCI_BASE | (register & 0x7FFF_FFFC) | (port & 3), whatever the access size.
- R6: For a data-port access while register bit 31 is 0, `phys_addr` = IO_BASE | port.
- R7: A valid access to any port that is neither 0xCF8 nor a data port gives `phys_addr` = IO_BASE | port, `uncached`=1 and `int_reg`=0.
- R8: When `acc_valid`=0, `phys_addr`, `uncached`, `int_reg` and `rdata` are all zero and the register does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_port | input | 16 | I/O port number |
| acc_size | input | 3 | Access width in bytes (1, 2 or 4) |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Write data |
| phys_addr | output | 64 | Physical request address |
| uncached | output | 1 | Request is an uncacheable port access |
| int_reg | output | 1 | Access targets the internal selector register |
| rdata | output | 32 | Selector value on a 4-byte read of 0xCF8 |

## Verification
The address, both flags and `rdata` are due in the same cycle the access is presented. A selector write takes effect at the clock edge that ends its cycle, so the access in the following cycle already sees the new value. The bench applies each access at the falling edge and pushes the expected result into a queue. The monitor pops and compares a quarter period later, well before the rising edge that could update the register. The bench's selector model is updated only after the expectation for that same access has been pushed.

// File: rtl/ioport_router.sv
module ioport_router #(
  parameter int          ADDR_W    = 64,
  parameter int          PORT_W    = 16,
  parameter int          DATA_W    = 32,
  parameter logic [63:0] IO_BASE   = 64'h8000_0000_0000_0000,
  parameter logic [63:0] PCI_BASE  = 64'hC000_0000_0000_0000,
  parameter logic [15:0] SEL_PORT  = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [PORT_W-1:0] acc_port,
  input  logic [2:0]        acc_size,
  input  logic              acc_write,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              uncached,
  output logic              int_reg,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] sel_q;
  logic              sel_hit, data_hit, sel_load;
  logic [ADDR_W-1:0] io_addr, pci_addr;

  assign sel_hit  = acc_valid && (acc_port == SEL_PORT) && (acc_size == 3'd4);
  assign data_hit = acc_valid && !sel_hit && ({acc_port[PORT_W-1:2], 2'b00} == DATA_PORT);
  assign sel_load = sel_hit && acc_write;

  assign io_addr  = IO_BASE | {{(ADDR_W-PORT_W){1'b0}}, acc_port};
  assign pci_addr = PCI_BASE | {{(ADDR_W-DATA_W+1){1'b0}}, sel_q[DATA_W-2:2], acc_port[1:0]};

  always_comb begin
    if (!acc_valid || sel_hit)          phys_addr = '0;
    else if (data_hit && sel_q[DATA_W-1]) phys_addr = pci_addr;
    else                                 phys_addr = io_addr;
  end

  assign uncached = acc_valid && !sel_hit;
  assign int_reg  = sel_hit;
  assign rdata    = (sel_hit && !acc_write) ? sel_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_q <= '0;
    else if (sel_load) sel_q <= acc_wdata;
  end

  assert_sel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_port == SEL_PORT && acc_size == 3'd4) |=> (sel_q == $past(acc_wdata)));

  assert_sel_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write && acc_port == SEL_PORT && acc_size == 3'd4) |=> $stable(sel_q));

  assert_flag_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (int_reg != uncached));

  assert_pci_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_hit && sel_q[DATA_W-1]) |-> (phys_addr[1:0] == acc_port[1:0] && phys_addr[ADDR_W-1:ADDR_W-2] == PCI_BASE[63:62]));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (phys_addr == '0 && !uncached && !int_reg && rdata == '0));

endmodule

// File: tb/ioport_router_bench.sv
module ioport_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] IO_B  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PCI_B = 64'hC000_0000_0000_0000;

  typedef struct {
    logic [63:0] addr;
    logic        unc;
    logic        intr;
    logic [31:0] rd;
    string       req;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic        acc_valid = 0, acc_write = 0;
  logic [15:0] acc_port = 0;
  logic [2:0]  acc_size = 0;
  logic [31:0] acc_wdata = 0;
  logic [63:0] phys_addr;
  logic        uncached, int_reg;
  logic [31:0] rdata;

  exp_t        q[$];
  logic [31:0] model_sel = 0;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ioport_router u_ioport_router (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_port(acc_port),
    .acc_size(acc_size), .acc_write(acc_write), .acc_wdata(acc_wdata),
    .phys_addr(phys_addr), .uncached(uncached), .int_reg(int_reg), .rdata(rdata));

  task automatic drive(input logic v, input logic [15:0] p, input logic [2:0] s,
                       input logic w, input logic [31:0] d, input string req);
    exp_t e;
    @(negedge clk);
    acc_valid = v; acc_port = p; acc_size = s; acc_write = w; acc_wdata = d;
    e.req = req; e.rd = 0;
    if (!v) begin
      e.addr = 0; e.unc = 0; e.intr = 0;
    end else if (p == 16'h0CF8 && s == 3'd4) begin
      e.addr = 0; e.unc = 0; e.intr = 1;
      if (!w) e.rd = model_sel;
    end else begin
      e.unc = 1; e.intr = 0;
      if ((p & 16'hFFFC) == 16'h0CFC && model_sel[31])
        e.addr = PCI_B | {32'h0, model_sel & 32'h7FFF_FFFC} | {62'h0, p[1:0]};
      else
        e.addr = IO_B | {48'h0, p};
    end
    q.push_back(e);
    if (v && w && p == 16'h0CF8 && s == 3'd4) model_sel = d;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (phys_addr !== e.addr || uncached !== e.unc || int_reg !== e.intr || rdata !== e.rd) begin
          errors++;
          $display("FAIL %s: got addr=%h unc=%b int=%b rd=%h, expected addr=%h unc=%b int=%b rd=%h",
                   e.req, phys_addr, uncached, int_reg, rdata, e.addr, e.unc, e.intr, e.rd);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    drive(0, 16'h0000, 3'd0, 0, 32'h0, "R8 idle after reset");
    drive(1, 16'h0CF8, 3'd4, 0, 32'h0, "R1 reset value read");
    drive(1, 16'h0060, 3'd1, 0, 32'h0, "R7 low port byte");
    drive(1, 16'hFFFF, 3'd2, 1, 32'h55, "R7 top port");
    drive(1, 16'h0CFD, 3'd1, 0, 32'h0, "R6 R4 data port, enable clear");
    drive(1, 16'h0CF8, 3'd4, 1, 32'h8012_3457, "R2 selector write");
    drive(1, 16'h0CF8, 3'd4, 0, 32'h0, "R2 selector readback");
    for (int i = 0; i < 4; i++)
      drive(1, 16'h0CFC + 16'(i), 3'd1, 0, 32'h0, "R5 R4 data port, enable set");
    drive(1, 16'h0CFE, 3'd4, 1, 32'h0, "R5 dword data port access");
    drive(1, 16'h0CF8, 3'd2, 1, 32'hFFFF_FFFF, "R3 word write to selector port");
    drive(1, 16'h0CF8, 3'd1, 0, 32'h0, "R3 byte read of selector port");
    drive(1, 16'h0CF8, 3'd4, 0, 32'h0, "R3 selector unchanged");
    drive(0, 16'h0CF8, 3'd4, 1, 32'hDEAD_BEEF, "R8 invalid write ignored");
    drive(1, 16'h0CF8, 3'd4, 0, 32'h0, "R8 selector unchanged after idle");
    drive(1, 16'h0CFB, 3'd1, 0, 32'h0, "R7 port below data range");
    drive(1, 16'h0D00, 3'd1, 0, 32'h0, "R7 port above data range");
    drive(1, 16'h0CF8, 3'd4, 1, 32'h7FFF_FFFF, "R2 selector write enable clear");
    drive(1, 16'h0CFF, 3'd2, 0, 32'h0, "R6 data port after clear");
    drive(0, 16'h0000, 3'd0, 0, 32'h0, "R8 final idle");
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule